// File: doc/BRIEF.md
# Split 64-bit Shift-and-Add Unit

This unit forms the 64-bit sum `a + (b << shamt)` as two cooperating halves that are issued in the same cycle. The low half takes the low word of `a`, the low (or only) word of `b` and a 3-bit immediate shift amount. It produces the lower 32 result bits. Over a private link it hands the upper half the carry-out of its adder, the bits of `b` that the shift pushed past bit 31, the sign of the low `b` word, the shift amount and the extension mode. The upper half adds those to the high word of `a`, and to the high word of `b` when `b` is a full 64-bit operand. It produces the upper 32 result bits.

Three extension modes share one datapath. In the wide mode, `b` is a full 64-bit value. In the zero-extend mode, `b` is a 32-bit unsigned offset and its high word is ignored. In the sign-extend mode, `b` is a 32-bit signed offset. The typical use is pointer arithmetic: a base pointer plus a scaled element offset. The low result word is final on its own, so a consumer can take it as the low pointer word. Both halves are combinational. The unit registers the joined 64-bit result once, so the result is visible one cycle after the request. The sum wraps modulo 2^64 and no overflow indication is produced.

Top module: `spadd_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low in the cycle after an edge that sampled it low.
- R2: While `rst_n` is low at a clock edge, the next cycle shows `out_valid`, `sum_lo` and `sum_hi` all zero.
- R3: With `mode` = 0 (wide), `{sum_hi,sum_lo}` equals `{a_hi,a_lo} + ({b_hi,b_lo} << shamt)` modulo 2^64. This includes carry propagation from the low word into the high word and wrap-around past 2^64.
- R4: With `mode` = 1 (zero-extend), the result equals `{a_hi,a_lo} + ({32'b0,b_lo} << shamt)` modulo 2^64, and `b_hi` has no effect on the result.
- R5: With `mode` = 2 (sign-extend), the result equals `{a_hi,a_lo}` plus `b_lo` sign-extended to 64 bits and then shifted left by `shamt`, modulo 2^64. A negative `b_lo` therefore lowers the 64-bit value.
- R6: `mode` = 3 is reserved and behaves exactly as `mode` = 1.
- R7: Every shift amount from 0 to 7 on `shamt` is applied to `b` before the addition, in every mode.
- R8: `sum_lo` depends only on `a_lo`, `b_lo` and `shamt`: it is the low 32 bits of `a_lo + (b_lo << shamt)` whatever the mode.
- R9: When `in_valid` is sampled low, `sum_lo` and `sum_hi` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe: operands present this cycle |
| mode | input | 2 | Extension of b: 0 wide, 1 zero-extend, 2 sign-extend, 3 reserved (as 1) |
| shamt | input | 3 | Left shift applied to b, 0 to 7 |
| a_lo | input | 32 | Low word of the base operand |
| a_hi | input | 32 | High word of the base operand |
| b_lo | input | 32 | Low word of b, or the whole 32-bit offset |
| b_hi | input | 32 | High word of b, used in wide mode only |
| out_valid | output | 1 | Result registers hold a new sum |
| sum_lo | output | 32 | Low 32 bits of the sum |
| sum_hi | output | 32 | High 32 bits of the sum |

## Verification
Each field of the link shows up in `sum_hi` one cycle after the request. A lost or mistimed carry shows as a high word that is off by one. Wrong spill bits show as an error of up to 127 in the high word, and only at nonzero shifts. A sign bit taken from the wrong place shows as a high word that lacks the all-ones extension for negative offsets. A fault in the low half shows in `sum_lo` in that same cycle, so sweeping every shift in every mode with a carry-generating pattern and a negative pattern exposes each field of the link.

// File: rtl/spadd_pkg.sv
// Package: shared encodings for the split shift-and-add unit.
// Assumes a 2-bit mode field; code 3 is reserved and decodes as zero-extend.
package spadd_pkg;

    typedef enum logic [1:0] {
        EXT_WIDE = 2'd0,   // b is a full 64-bit operand
        EXT_ZERO = 2'd1,   // b is 32-bit unsigned
        EXT_SIGN = 2'd2,   // b is 32-bit signed
        EXT_RSVD = 2'd3    // reserved, treated as EXT_ZERO
    } ext_mode_e;

    // Fold the reserved code onto the zero-extend behaviour.
    function automatic ext_mode_e decode_mode(input logic [1:0] raw);
        ext_mode_e m;
        case (raw)
            2'd0:    m = EXT_WIDE;
            2'd2:    m = EXT_SIGN;
            default: m = EXT_ZERO;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/spadd_lo_stage.sv
// Module: low half of the split adder.
// Shifts the low b word left by shamt and adds it to the low a word.
// Emits the low result word plus the link to the high half: carry-out,
// spilled b bits, sign of b_lo, shift amount and decoded mode.
// Assumes SPW = 2**SHW - 1, so every bit that leaves the word fits the spill.
module spadd_lo_stage
    import spadd_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 3,
    parameter int SPW = (1 << SHW) - 1
) (
    input  logic [1:0]     mode_raw,
    input  logic [SHW-1:0] shamt,
    input  logic [W-1:0]   a_lo,
    input  logic [W-1:0]   b_lo,
    output logic [W-1:0]   res_lo,
    output logic           lk_carry,
    output logic [SPW-1:0] lk_spill,
    output logic           lk_sign,
    output logic [SHW-1:0] lk_shamt,
    output ext_mode_e      lk_mode
);

    localparam int EXTW = W + SPW;

    logic [EXTW-1:0] shifted;
    logic [W:0]      lo_sum;

    // Widen b_lo so the shift keeps every bit pushed past the word boundary.
    always_comb begin
        shifted = {{SPW{1'b0}}, b_lo} << shamt;
    end

    // One W-bit add with a carry bit beside it.
    always_comb begin
        lo_sum = {1'b0, a_lo} + {1'b0, shifted[W-1:0]};
    end

    // Drive the result word and every field of the link.
    always_comb begin
        res_lo   = lo_sum[W-1:0];
        lk_carry = lo_sum[W];
        lk_spill = shifted[EXTW-1:W];
        lk_sign  = b_lo[W-1];
        lk_shamt = shamt;
        lk_mode  = decode_mode(mode_raw);
    end

endmodule

// File: rtl/spadd_hi_stage.sv
// Module: high half of the split adder.
// Builds the high word of the shifted, extended b from the link and, in
// wide mode, from b_hi, then adds a_hi and the low-half carry.
// Assumes the link comes from a low half acting in the same cycle.
module spadd_hi_stage
    import spadd_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 3,
    parameter int SPW = (1 << SHW) - 1
) (
    input  logic [W-1:0]   a_hi,
    input  logic [W-1:0]   b_hi,
    input  logic           lk_carry,
    input  logic [SPW-1:0] lk_spill,
    input  logic           lk_sign,
    input  logic [SHW-1:0] lk_shamt,
    input  ext_mode_e      lk_mode,
    output logic [W-1:0]   res_hi
);

    logic [W-1:0] upper_src;
    logic [W-1:0] upper_op;
    logic [W-1:0] spill_w;

    // Pick the unshifted high word of b for the current mode.
    always_comb begin
        case (lk_mode)
            EXT_WIDE: upper_src = b_hi;
            EXT_SIGN: upper_src = {W{lk_sign}};
            default:  upper_src = '0;
        endcase
    end

    // Shift the high word and merge in the bits spilled by the low half.
    always_comb begin
        spill_w  = {{(W-SPW){1'b0}}, lk_spill};
        upper_op = (upper_src << lk_shamt) | spill_w;
    end

    // Final high add, modulo 2^W.
    always_comb begin
        res_hi = a_hi + upper_op + {{(W-1){1'b0}}, lk_carry};
    end

endmodule

// File: rtl/spadd_unit.sv
// Module: top of the split 64-bit shift-and-add unit.
// Joins the low and high halves over their private link within one cycle
// and registers the 2W-bit result on an accepted request.
// Assumes a synchronous active-low reset; the result holds between requests.
module spadd_unit
    import spadd_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [1:0]     mode,
    input  logic [SHW-1:0] shamt,
    input  logic [W-1:0]   a_lo,
    input  logic [W-1:0]   a_hi,
    input  logic [W-1:0]   b_lo,
    input  logic [W-1:0]   b_hi,
    output logic           out_valid,
    output logic [W-1:0]   sum_lo,
    output logic [W-1:0]   sum_hi
);

    localparam int SPW = (1 << SHW) - 1;

    logic [W-1:0]   lo_word;
    logic [W-1:0]   hi_word;
    logic           lk_carry;
    logic [SPW-1:0] lk_spill;
    logic           lk_sign;
    logic [SHW-1:0] lk_shamt;
    ext_mode_e      lk_mode;

    spadd_lo_stage #(.W(W), .SHW(SHW), .SPW(SPW)) u_lo (
        .mode_raw (mode),
        .shamt    (shamt),
        .a_lo     (a_lo),
        .b_lo     (b_lo),
        .res_lo   (lo_word),
        .lk_carry (lk_carry),
        .lk_spill (lk_spill),
        .lk_sign  (lk_sign),
        .lk_shamt (lk_shamt),
        .lk_mode  (lk_mode)
    );

    spadd_hi_stage #(.W(W), .SHW(SHW), .SPW(SPW)) u_hi (
        .a_hi     (a_hi),
        .b_hi     (b_hi),
        .lk_carry (lk_carry),
        .lk_spill (lk_spill),
        .lk_sign  (lk_sign),
        .lk_shamt (lk_shamt),
        .lk_mode  (lk_mode),
        .res_hi   (hi_word)
    );

    // Output strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the joined result on a request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_lo <= '0;
            sum_hi <= '0;
        end else if (in_valid) begin
            sum_lo <= lo_word;
            sum_hi <= hi_word;
        end
    end

endmodule

// File: rtl/spadd_chk.sv
// Module: property checker for spadd_unit, attached by bind.
// Holds a 2W-bit reference of the sum and compares registered outputs.
module spadd_chk #(
    parameter int W   = 32,
    parameter int SHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [1:0]     mode,
    input logic [SHW-1:0] shamt,
    input logic [W-1:0]   a_lo,
    input logic [W-1:0]   a_hi,
    input logic [W-1:0]   b_lo,
    input logic [W-1:0]   b_hi,
    input logic           out_valid,
    input logic [W-1:0]   sum_lo,
    input logic [W-1:0]   sum_hi
);

    logic [2*W-1:0] ref_wide;
    logic [2*W-1:0] ref_zero;
    logic [2*W-1:0] ref_sign;
    logic [W-1:0]   ref_low;

    // Independent 2W-bit reference sums for each extension.
    always_comb begin
        ref_wide = {a_hi, a_lo} + ({b_hi, b_lo} << shamt);
        ref_zero = {a_hi, a_lo} + ({{W{1'b0}}, b_lo} << shamt);
        ref_sign = {a_hi, a_lo} + ({{W{b_lo[W-1]}}, b_lo} << shamt);
        ref_low  = a_lo + (b_lo << shamt);
    end

    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum_lo == '0 && sum_hi == '0));
    a_r3_wide_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=> ({sum_hi, sum_lo} == $past(ref_wide)));
    a_r4_zero_ext_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 2'd1 || mode == 2'd3)) |=> ({sum_hi, sum_lo} == $past(ref_zero))); // R6 too
    a_r5_sign_ext_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=> ({sum_hi, sum_lo} == $past(ref_sign)));
    a_r8_low_mode_free: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sum_lo == $past(ref_low)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_lo) && $stable(sum_hi)));

endmodule

bind spadd_unit spadd_chk #(.W(W), .SHW(SHW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .shamt     (shamt),
    .a_lo      (a_lo),
    .a_hi      (a_hi),
    .b_lo      (b_lo),
    .b_hi      (b_hi),
    .out_valid (out_valid),
    .sum_lo    (sum_lo),
    .sum_hi    (sum_hi)
);

// File: tb/sim_spadd_unit.sv
// Bench: directed scenarios for spadd_unit, one task each.
module sim_spadd_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  shamt = 3'd0;
    logic [31:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic        out_valid;
    logic [31:0] sum_lo, sum_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spadd_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .shamt(shamt), .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
        .out_valid(out_valid), .sum_lo(sum_lo), .sum_hi(sum_hi)
    );

    // Reference sum written from the requirements.
    function automatic logic [63:0] model(input logic [1:0] m, input logic [2:0] s,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] bx;
        case (m)
            2'd0:    bx = b;
            2'd2:    bx = {{32{b[31]}}, b[31:0]};
            default: bx = {32'b0, b[31:0]};
        endcase
        return a + (bx << s);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge; sample just after the capture edge.
    task automatic issue(input logic [1:0] m, input logic [2:0] s,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = m; shamt = s;
        a_lo = a[31:0]; a_hi = a[63:32]; b_lo = b[31:0]; b_hi = b[63:32];
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R2 out_valid", {63'b0, out_valid}, 64'd0);
        check("R2 sum", {sum_hi, sum_lo}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [63:0] a, b;
                    a = 64'h0123_4567_89AB_CDEF * (p + 3) + 64'hFFFF_FFFF * p;
                    b = 64'hFEDC_BA98_F654_3211 ^ (64'h1357_9BDF_8642_0ACE * p);
                    issue(m[1:0], s[2:0], a, b);
                    check("R1 out_valid", {63'b0, out_valid}, 64'd1);
                    check($sformatf("R7 mode%0d shamt%0d (R3/R4/R5/R6)", m, s),
                          {sum_hi, sum_lo}, model(m[1:0], s[2:0], a, b));
                    check("R8 low word", {32'b0, sum_lo},
                          {32'b0, a[31:0] + (b[31:0] << s)});
                end
            end
        end
    endtask

    task automatic t_carry();
        issue(2'd0, 3'd0, 64'h0000_0005_FFFF_FFFF, 64'h0000_0000_0000_0001);
        check("R3 carry into high", {sum_hi, sum_lo}, 64'h0000_0006_0000_0000);
        issue(2'd0, 3'd7, 64'hFFFF_FFFF_FFFF_FF80, 64'h0000_0000_0000_0001);
        check("R3 wrap", {sum_hi, sum_lo}, 64'h0);
        issue(2'd1, 3'd7, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        check("R4 spill plus carry", {sum_hi, sum_lo}, 64'h0000_0080_7FFF_FF80);
    endtask

    task automatic t_negative();
        issue(2'd2, 3'd3, 64'h0000_0001_0000_0100, 64'h0000_0000_FFFF_FFF8);
        check("R5 negative offset", {sum_hi, sum_lo}, 64'h0000_0001_0000_00C0);
        issue(2'd2, 3'd1, 64'h0000_0001_0000_0000, 64'h1234_5678_FFFF_FFFF);
        check("R5 borrow from high", {sum_hi, sum_lo}, 64'h0000_0000_FFFF_FFFE);
    endtask

    task automatic t_ignore_bhi();
        issue(2'd1, 3'd2, 64'h1111_1111_2222_2222, 64'h0000_0000_4000_0001);
        check("R4 b_hi zero", {sum_hi, sum_lo}, 64'h1111_1112_2222_2226);
        issue(2'd1, 3'd2, 64'h1111_1111_2222_2222, 64'hDEAD_BEEF_4000_0001);
        check("R4 b_hi ignored", {sum_hi, sum_lo}, 64'h1111_1112_2222_2226);
        issue(2'd3, 3'd2, 64'h1111_1111_2222_2222, 64'hDEAD_BEEF_4000_0001);
        check("R6 reserved as zero-extend", {sum_hi, sum_lo}, 64'h1111_1112_2222_2226);
    endtask

    task automatic t_hold();
        issue(2'd0, 3'd4, 64'h0000_0000_0000_0010, 64'h0000_0001_0000_0001);
        check("R9 setup", {sum_hi, sum_lo}, 64'h0000_0010_0000_0020);
        a_lo = 32'hAAAA_AAAA; a_hi = 32'h5555_5555; b_lo = 32'h1; mode = 2'd2;
        repeat (3) @(posedge clk);
        #1;
        check("R1 idle strobe", {63'b0, out_valid}, 64'd0);
        check("R9 held", {sum_hi, sum_lo}, 64'h0000_0010_0000_0020);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_carry();
        t_negative();
        t_ignore_bhi();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule